// File: doc/BRIEF.md
# Transition-order detector

This block watches two synchronous control bits, `x1` and `x2`, and raises `z` only when the pair reaches the combination 11 by way of 01. Its output depends on the path the inputs took as well as on their present values. If the pair moves from 10 or from 00 straight to 11, `z` stays low. If it moves from 01 to 11, `z` goes high at once.

The block samples the inputs on every rising clock edge. The inputs must already be synchronous to `clk`. Two small registers hold the history:

- the combination seen on the last edge;
- the distinct combination that came before that one.

Repeated samples of the same value leave the history unchanged. `z` is formed from the present inputs and this history. It therefore rises in the cycle the inputs reach 11 and falls in the cycle they leave it.

In the text below, a combination is written as two digits, `x1` first and `x2` second. So 01 means `x1`=0 and `x2`=1.

Top module: `order_watch`

## Requirements
- R1: While `rst_n` is low, `z` is 0 whatever the inputs are. After `rst_n` is released, the remembered preceding combination is 00.
- R2: `z` is 0 in every cycle where the present combination is not 11.
- R3: When the inputs change from 01 to 11, `z` is 1 in the first cycle that shows 11.
- R4: When 11 is entered from 10, `z` stays 0 for the whole stay at 11.
- R5: When 11 is entered from 00, including straight after reset, `z` stays 0 for the whole stay at 11.
- R6: Once asserted, `z` stays 1 for as long as the inputs stay at 11.
- R7: `z` falls to 0 in the same cycle that the inputs leave 11.
- R8: The history changes only when the sampled combination changes. Any number of repeated samples of 01 before 11 still count as an entry from 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x1 | input | 1 | First watched bit, synchronous to `clk` |
| x2 | input | 1 | Second watched bit, synchronous to `clk` |
| z | output | 1 | High while the inputs are at 11 after arriving from 01 |

## Verification
The assertions assume that `x1` and `x2` change only between rising edges and hold steady around each edge. They also assume that `rst_n` is low from time zero, so the first history value is defined. The stimulus changes the inputs just after each falling edge and reads `z` shortly afterwards, well away from the sampling edge. Every reset returns the inputs to 00 before `rst_n` is released. The sweep applies every four-step sequence of combinations starting from reset. Directed runs add long stays at 11 and repeated samples of 01 before 11.

// File: rtl/order_watch_pkg.sv
package order_watch_pkg;

  localparam int unsigned PAIR_W = 2;

  typedef enum logic [PAIR_W-1:0] {
    PAIR_IDLE = 2'b00,
    PAIR_ARM  = 2'b01,
    PAIR_SIDE = 2'b10,
    PAIR_TOP  = 2'b11
  } pair_e;

  function automatic pair_e pack_pair(input logic a, input logic b);
    return pair_e'({a, b});
  endfunction

endpackage

// File: rtl/order_watch_history.sv
module order_watch_history
  import order_watch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pair_e cur,
  output pair_e last_q,
  output pair_e before_q
);

  logic changed;

  assign changed = (cur != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= PAIR_IDLE;
      before_q <= PAIR_IDLE;
    end else if (changed) begin
      before_q <= last_q;
      last_q   <= cur;
    end
  end

  AST_REPEAT_KEEPS_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == last_q) |=> $stable(before_q)); // R8

  AST_CHANGE_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != last_q) |=> (before_q == $past(last_q))); // R8

endmodule

// File: rtl/order_watch_decide.sv
module order_watch_decide
  import order_watch_pkg::*;
(
  input  pair_e cur,
  input  pair_e last_q,
  input  pair_e before_q,
  output logic  hit
);

  logic fresh_entry;
  logic dwell_entry;

  always_comb begin
    fresh_entry = (last_q == PAIR_ARM);
    dwell_entry = (last_q == PAIR_TOP) && (before_q == PAIR_ARM);
    hit         = (cur == PAIR_TOP) && (fresh_entry || dwell_entry);
  end

endmodule

// File: rtl/order_watch.sv
module order_watch
  import order_watch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic x1,
  input  logic x2,
  output logic z
);

  pair_e cur;
  pair_e last_q;
  pair_e before_q;
  logic  hit;

  assign cur = pack_pair(x1, x2);

  order_watch_history u_history (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (cur),
    .last_q   (last_q),
    .before_q (before_q)
  );

  order_watch_decide u_decide (
    .cur      (cur),
    .last_q   (last_q),
    .before_q (before_q),
    .hit      (hit)
  );

  assign z = hit && rst_n;

  AST_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    z |-> (x1 && x2)); // R2

  AST_ARM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && x1 && x2 && !$past(x1) && $past(x2)) |-> z); // R3

  AST_SIDE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (x1 && x2 && $past(x1) && !$past(x2)) |-> !z); // R4

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (x1 && x2 && !$past(x1) && !$past(x2)) |-> !z); // R5

  AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(z) && x1 && x2 && $past(x1) && $past(x2)) |-> z); // R6

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> !z); // R1

endmodule

// File: tb/test_order_watch.sv
`timescale 1ns/100ps
module test_order_watch;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x1 = 1'b0;
  logic x2 = 1'b0;
  logic z;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  order_watch i_order_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .x1    (x1),
    .x2    (x2),
    .z     (z)
  );

  task automatic check(input logic exp, input string req);
    n_checks++;
    if (z !== exp) begin
      n_fail++;
      $display("FAIL %s: z=%b expected %b (x1x2=%b%b)", req, z, exp, x1, x2);
    end
  endtask

  // Apply a combination just after the falling edge, then read z.
  task automatic step(input logic [1:0] v);
    @(negedge clk);
    {x1, x2} = v;
    #1;
  endtask

  // R1: z stays low during reset even with 11 applied.
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {x1, x2} = 2'b11;
    #1;
    check(1'b0, "R1");
    @(posedge clk);
    @(negedge clk);
    {x1, x2} = 2'b00;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Expected z from the requirements: walk back over the run of 11
  // that ends at position k; the combination before that run is
  // 00 at the start (R1) and must be 01.
  function automatic logic expect_z(input logic [1:0] s[4], input int k);
    int j;
    logic [1:0] pred;
    if (s[k] != 2'b11) return 1'b0;
    j = k;
    while (j >= 0 && s[j] == 2'b11) j--;
    pred = (j < 0) ? 2'b00 : s[j];
    return pred == 2'b01;
  endfunction

  function automatic string tag_of(input logic [1:0] s[4], input int k);
    int j;
    logic [1:0] pred;
    if (s[k] != 2'b11) return (k > 0 && s[k-1] == 2'b11) ? "R7" : "R2";
    j = k;
    while (j >= 0 && s[j] == 2'b11) j--;
    pred = (j < 0) ? 2'b00 : s[j];
    if (j < k - 1) return (pred == 2'b01) ? "R6" : (pred == 2'b10 ? "R4" : "R5");
    if (pred == 2'b01) return (j > 0 && s[j-1] == 2'b01) ? "R8" : "R3";
    return (pred == 2'b10) ? "R4" : "R5";
  endfunction

  initial begin
    logic [1:0] seq[4];
    do_reset();
    check(1'b0, "R1");

    // Sweep every four-step sequence, each one starting from reset.
    for (int code = 0; code < 256; code++) begin
      do_reset();
      for (int i = 0; i < 4; i++) seq[i] = 2'((code >> (2 * i)) & 3);
      for (int i = 0; i < 4; i++) begin
        step(seq[i]);
        check(expect_z(seq, i), tag_of(seq, i));
      end
    end

    // R8: repeated samples of 01, then a long stay at 11 (R6), then leave (R7).
    do_reset();
    for (int i = 0; i < 7; i++) begin
      step(2'b01);
      check(1'b0, "R2");
    end
    step(2'b11);
    check(1'b1, "R8");
    for (int i = 0; i < 20; i++) begin
      step(2'b11);
      check(1'b1, "R6");
    end
    step(2'b10);
    check(1'b0, "R7");

    // R4: a long stay at 11 entered from 10.
    for (int i = 0; i < 15; i++) begin
      step(2'b11);
      check(1'b0, "R4");
    end
    step(2'b01);
    check(1'b0, "R7");
    step(2'b11);
    check(1'b1, "R3");

    // R5: a long stay at 11 entered from 00.
    step(2'b00);
    check(1'b0, "R7");
    for (int i = 0; i < 15; i++) begin
      step(2'b11);
      check(1'b0, "R5");
    end

    // R1: reset clears the history of 01.
    step(2'b01);
    do_reset();
    step(2'b11);
    check(1'b0, "R1");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule